// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out where control flow goes next when a jump, call or trap entry is executed. It takes a branch mode, the operand fields of the instruction, the current instruction pointer (which already points past the branch), a general register value and the branch length. From these it produces the next instruction pointer and, when the mode changes it, the next code segment. It also raises a trap for odd code targets and flags relative branches whose target is the branch itself.

The mode codes are 0 absolute, 1 relative, 2 register-indirect, 3 segment-plus-address and 4 trap entry. Codes 5 to 7 are reserved. A request is taken on a clock edge where `take_i` is high. The results appear registered on the next edge, together with a one-cycle `vld_o` pulse. Fetching and stack handling happen elsewhere.

Top module: `bta_branch_target`

## Requirements
- R1: Mode 0 (absolute) with an even `addr_i` sets `nxt_ip_o` to `addr_i` and leaves `seg_we_o` low.
- R2: In modes 0, 2 and 3, an odd code target (`addr_i[0]` for modes 0 and 3, `gpr_i[0]` for mode 2) sets `odd_trap_o` to 1, sets `nxt_ip_o` to `cur_ip_i` and holds `seg_we_o` low.
- R3: Mode 1 (relative) sets `nxt_ip_o` to `cur_ip_i` plus twice `rel_i` read as a signed 8-bit value, modulo 2^16. Values 0x00 to 0x7F go forward and 0x80 to 0xFF go backward.
- R4: `self_loop_o` is 1 only in mode 1, and only when the target equals the branch's own address: `rel_i`=0xFF with `len4_i`=0 (2-byte branch), or `rel_i`=0xFE with `len4_i`=1 (4-byte branch).
- R5: Mode 2 (register-indirect) with an even `gpr_i` sets `nxt_ip_o` to `gpr_i` unchanged. No page translation is applied.
- R6: Mode 3 with an even `addr_i` sets `nxt_seg_o` to the low 8 bits of `seg_op_i`, sets `seg_we_o` to 1 and sets `nxt_ip_o` to `addr_i`.
- R7: Mode 4 (trap entry) sets `nxt_ip_o` to 4 times `trap_no_i` (0x000 to 0x1FC), sets `nxt_seg_o` to 0 and `seg_we_o` to 1, and never raises `odd_trap_o`.
- R8: Results appear on the clock edge after the one where `take_i` is high. `vld_o` is high for exactly that cycle. While `take_i` is low, all other outputs hold their values.
- R9: While reset is asserted, every output is 0.
- R10: Reserved modes 5 to 7 set `nxt_ip_o` to `cur_ip_i` and keep `seg_we_o`, `odd_trap_o` and `self_loop_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Request strobe; inputs are captured on this edge |
| mode_i | input | 3 | Branch mode code |
| addr_i | input | 16 | Absolute in-segment code address |
| rel_i | input | 8 | Signed relative word offset |
| seg_op_i | input | 16 | Segment operand; only the low 8 bits are used |
| trap_no_i | input | 7 | Trap number |
| gpr_i | input | 16 | Word register value for indirect targets |
| cur_ip_i | input | 16 | IP of the instruction after the branch |
| len4_i | input | 1 | 1 for a 4-byte branch, 0 for a 2-byte branch |
| nxt_ip_o | output | 16 | Next instruction pointer |
| nxt_seg_o | output | 8 | Next code segment |
| seg_we_o | output | 1 | Code segment write enable |
| odd_trap_o | output | 1 | Odd code target trap |
| self_loop_o | output | 1 | Relative branch targets itself |
| vld_o | output | 1 | Result valid pulse |

## Verification
Every result has a latency of exactly one edge after the `take_i` edge. This covers the next IP, the segment and its write enable, the odd-target trap, the self-loop flag and `vld_o`. Each scenario task drives its inputs on a falling edge and holds `take_i` for one cycle. It then reads the outputs on the next falling edge, half a period after the capture edge. The hold test reads again one full cycle later with `take_i` low and new input values applied, to confirm that nothing has moved.

// File: rtl/bta_pkg.sv
package bta_pkg;
  parameter int IP_W  = 16;
  parameter int SEG_W = 8;

  typedef enum logic [2:0] {
    BM_ABS  = 3'd0,
    BM_REL  = 3'd1,
    BM_IND  = 3'd2,
    BM_SEG  = 3'd3,
    BM_TRAP = 3'd4
  } bmode_e;

  typedef struct packed {
    logic [IP_W-1:0]  ip;
    logic [SEG_W-1:0] seg;
    logic             seg_we;
    logic             odd_trap;
    logic             self_loop;
  } bres_t;
endpackage

// File: rtl/bta_rel_unit.sv
module bta_rel_unit #(
  parameter int IP_W  = 16,
  parameter int REL_W = 8
) (
  input  logic [IP_W-1:0]  cur_ip_i,
  input  logic [REL_W-1:0] rel_i,
  input  logic             len4_i,
  output logic [IP_W-1:0]  tgt_o,
  output logic             loop_o
);
  localparam int EXT_W = IP_W - REL_W - 1;

  logic [IP_W-1:0] disp;
  logic [IP_W-1:0] own_addr;

  // word offset: sign-extend and scale by two; the sum wraps modulo 2^IP_W
  assign disp     = {{EXT_W{rel_i[REL_W-1]}}, rel_i, 1'b0};
  assign tgt_o    = cur_ip_i + disp;
  assign own_addr = cur_ip_i - (len4_i ? IP_W'(4) : IP_W'(2));
  assign loop_o   = (tgt_o == own_addr);
endmodule

// File: rtl/bta_target_sel.sv
module bta_target_sel
  import bta_pkg::*;
#(
  parameter int SEG_OP_W = 16,
  parameter int TRAP_W   = 7,
  parameter int VEC_SH   = 2
) (
  input  bmode_e              mode_i,
  input  logic [IP_W-1:0]     addr_i,
  input  logic [SEG_OP_W-1:0] seg_op_i,
  input  logic [TRAP_W-1:0]   trap_no_i,
  input  logic [IP_W-1:0]     gpr_i,
  input  logic [IP_W-1:0]     cur_ip_i,
  input  logic [IP_W-1:0]     rel_tgt_i,
  input  logic                rel_loop_i,
  output bres_t               res_o
);
  localparam int VEC_PAD = IP_W - TRAP_W - VEC_SH;

  logic [IP_W-1:0] vec_addr;
  assign vec_addr = {{VEC_PAD{1'b0}}, trap_no_i, {VEC_SH{1'b0}}};

  always_comb begin
    res_o           = '0;
    res_o.ip        = cur_ip_i;
    case (mode_i)
      BM_ABS: begin
        if (addr_i[0]) res_o.odd_trap = 1'b1;
        else           res_o.ip       = addr_i;
      end
      BM_REL: begin
        res_o.ip        = rel_tgt_i;
        res_o.self_loop = rel_loop_i;
      end
      BM_IND: begin
        if (gpr_i[0]) res_o.odd_trap = 1'b1;
        else          res_o.ip       = gpr_i;
      end
      BM_SEG: begin
        if (addr_i[0]) begin
          res_o.odd_trap = 1'b1;
        end else begin
          res_o.ip     = addr_i;
          res_o.seg    = seg_op_i[SEG_W-1:0];
          res_o.seg_we = 1'b1;
        end
      end
      BM_TRAP: begin
        res_o.ip     = vec_addr;
        res_o.seg    = '0;
        res_o.seg_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bta_out_reg.sv
module bta_out_reg
  import bta_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  bres_t res_d_i,
  output bres_t res_q_o,
  output logic  vld_q_o
);
  bres_t res_d;
  logic  vld_d;

  always_comb begin
    res_d = res_q_o;
    if (en_i) res_d = res_d_i;
    vld_d = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q_o <= '0;
      vld_q_o <= 1'b0;
    end else begin
      res_q_o <= res_d;
      vld_q_o <= vld_d;
    end
  end
endmodule

// File: rtl/bta_branch_target.sv
module bta_branch_target
  import bta_pkg::*;
#(
  parameter int REL_W    = 8,
  parameter int SEG_OP_W = 16,
  parameter int TRAP_W   = 7,
  parameter int VEC_SH   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic [2:0]          mode_i,
  input  logic [IP_W-1:0]     addr_i,
  input  logic [REL_W-1:0]    rel_i,
  input  logic [SEG_OP_W-1:0] seg_op_i,
  input  logic [TRAP_W-1:0]   trap_no_i,
  input  logic [IP_W-1:0]     gpr_i,
  input  logic [IP_W-1:0]     cur_ip_i,
  input  logic                len4_i,
  output logic [IP_W-1:0]     nxt_ip_o,
  output logic [SEG_W-1:0]    nxt_seg_o,
  output logic                seg_we_o,
  output logic                odd_trap_o,
  output logic                self_loop_o,
  output logic                vld_o
);
  logic [IP_W-1:0] rel_tgt;
  logic            rel_loop;
  bres_t           res_d;
  bres_t           res_q;

  bta_rel_unit #(.IP_W(IP_W), .REL_W(REL_W)) u_rel (
    .cur_ip_i (cur_ip_i),
    .rel_i    (rel_i),
    .len4_i   (len4_i),
    .tgt_o    (rel_tgt),
    .loop_o   (rel_loop)
  );

  bta_target_sel #(.SEG_OP_W(SEG_OP_W), .TRAP_W(TRAP_W), .VEC_SH(VEC_SH)) u_sel (
    .mode_i     (bmode_e'(mode_i)),
    .addr_i     (addr_i),
    .seg_op_i   (seg_op_i),
    .trap_no_i  (trap_no_i),
    .gpr_i      (gpr_i),
    .cur_ip_i   (cur_ip_i),
    .rel_tgt_i  (rel_tgt),
    .rel_loop_i (rel_loop),
    .res_o      (res_d)
  );

  bta_out_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (take_i),
    .res_d_i (res_d),
    .res_q_o (res_q),
    .vld_q_o (vld_o)
  );

  assign nxt_ip_o    = res_q.ip;
  assign nxt_seg_o   = res_q.seg;
  assign seg_we_o    = res_q.seg_we;
  assign odd_trap_o  = res_q.odd_trap;
  assign self_loop_o = res_q.self_loop;
endmodule

// File: rtl/bta_branch_target_chk.sv
module bta_branch_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_i,
  input logic [2:0]  mode_i,
  input logic [15:0] addr_i,
  input logic [15:0] gpr_i,
  input logic [15:0] cur_ip_i,
  input logic [15:0] nxt_ip_o,
  input logic [7:0]  nxt_seg_o,
  input logic        seg_we_o,
  input logic        odd_trap_o,
  input logic        self_loop_o,
  input logic        vld_o
);
  a_r1_abs_even: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mode_i == 3'd0 && !addr_i[0]) |=> (nxt_ip_o == $past(addr_i) && !seg_we_o));

  a_r2_odd_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && ((mode_i == 3'd0 && addr_i[0]) || (mode_i == 3'd2 && gpr_i[0])))
      |=> (odd_trap_o && !seg_we_o && nxt_ip_o == $past(cur_ip_i)));

  a_r2_trap_no_seg: assert property (@(posedge clk) disable iff (!rst_n)
    !(odd_trap_o && seg_we_o));

  a_r4_loop_rel_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mode_i != 3'd1) |=> !self_loop_o);

  a_r5_ind_even: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mode_i == 3'd2 && !gpr_i[0]) |=> (nxt_ip_o == $past(gpr_i)));

  a_r7_trap_seg0: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && mode_i == 3'd4) |=> (seg_we_o && nxt_seg_o == 8'h00 && !odd_trap_o && nxt_ip_o[1:0] == 2'b00));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> (!vld_o && $stable(nxt_ip_o) && $stable(nxt_seg_o) && $stable(seg_we_o)
                 && $stable(odd_trap_o) && $stable(self_loop_o)));

  a_r8_vld: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> vld_o);
endmodule

bind bta_branch_target bta_branch_target_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .take_i      (take_i),
  .mode_i      (mode_i),
  .addr_i      (addr_i),
  .gpr_i       (gpr_i),
  .cur_ip_i    (cur_ip_i),
  .nxt_ip_o    (nxt_ip_o),
  .nxt_seg_o   (nxt_seg_o),
  .seg_we_o    (seg_we_o),
  .odd_trap_o  (odd_trap_o),
  .self_loop_o (self_loop_o),
  .vld_o       (vld_o)
);

// File: tb/bta_branch_target_tb.sv
`timescale 1ns/1ps
module bta_branch_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0]  rel_i = '0;
  logic [15:0] seg_op_i = '0;
  logic [6:0]  trap_no_i = '0;
  logic [15:0] gpr_i = '0;
  logic [15:0] cur_ip_i = '0;
  logic        len4_i = 1'b0;
  logic [15:0] nxt_ip_o;
  logic [7:0]  nxt_seg_o;
  logic        seg_we_o, odd_trap_o, self_loop_o, vld_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bta_branch_target dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .mode_i(mode_i), .addr_i(addr_i),
    .rel_i(rel_i), .seg_op_i(seg_op_i), .trap_no_i(trap_no_i), .gpr_i(gpr_i),
    .cur_ip_i(cur_ip_i), .len4_i(len4_i), .nxt_ip_o(nxt_ip_o), .nxt_seg_o(nxt_seg_o),
    .seg_we_o(seg_we_o), .odd_trap_o(odd_trap_o), .self_loop_o(self_loop_o), .vld_o(vld_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one request, then sample on the following falling edge
  task automatic issue(input logic [2:0] m, input logic [15:0] a, input logic [7:0] r,
                       input logic [15:0] s, input logic [6:0] t, input logic [15:0] g,
                       input logic [15:0] ip, input logic l4);
    @(negedge clk);
    mode_i = m; addr_i = a; rel_i = r; seg_op_i = s; trap_no_i = t; gpr_i = g;
    cur_ip_i = ip; len4_i = l4; take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
  endtask

  task automatic expect_all(input string req, input logic [15:0] ip, input logic [7:0] seg,
                            input logic we, input logic odd, input logic loop);
    chk({req, " vld"}, 32'(vld_o), 32'd1);
    chk({req, " ip"}, 32'(nxt_ip_o), 32'(ip));
    chk({req, " seg_we"}, 32'(seg_we_o), 32'(we));
    if (we) chk({req, " seg"}, 32'(nxt_seg_o), 32'(seg));
    chk({req, " odd_trap"}, 32'(odd_trap_o), 32'(odd));
    chk({req, " self_loop"}, 32'(self_loop_o), 32'(loop));
  endtask

  function automatic logic [15:0] rel_exp(input logic [15:0] ip, input logic [7:0] r);
    int v;
    v = int'(ip) + 2 * int'($signed(r));
    return 16'(v & 32'hFFFF);
  endfunction

  task automatic t_reset();
    chk("R9 ip", 32'(nxt_ip_o), 0);
    chk("R9 seg", 32'(nxt_seg_o), 0);
    chk("R9 flags", {28'd0, seg_we_o, odd_trap_o, self_loop_o, vld_o}, 0);
  endtask

  task automatic t_abs();
    issue(3'd0, 16'hBEEE, 8'h00, 16'h0055, 7'd0, 16'h0, 16'h1000, 1'b0);
    expect_all("R1", 16'hBEEE, 8'h00, 1'b0, 1'b0, 1'b0);
    issue(3'd0, 16'h2223, 8'h00, 16'h0, 7'd0, 16'h0, 16'h1000, 1'b0);
    expect_all("R2 abs odd", 16'h1000, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_rel();
    logic [7:0] offs [6] = '{8'h00, 8'h7F, 8'h80, 8'h10, 8'hF0, 8'h01};
    logic [15:0] ips [6] = '{16'h4000, 16'h4000, 16'h4000, 16'hFFFE, 16'h0004, 16'h8000};
    for (int i = 0; i < 6; i++) begin
      issue(3'd1, 16'h0, offs[i], 16'h0, 7'd0, 16'h0, ips[i], 1'b0);
      expect_all("R3", rel_exp(ips[i], offs[i]), 8'h00, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_loop();
    issue(3'd1, 16'h0, 8'hFF, 16'h0, 7'd0, 16'h0, 16'h0302, 1'b0);
    expect_all("R4 2-byte", 16'h0300, 8'h00, 1'b0, 1'b0, 1'b1);
    issue(3'd1, 16'h0, 8'hFE, 16'h0, 7'd0, 16'h0, 16'h0304, 1'b1);
    expect_all("R4 4-byte", 16'h0300, 8'h00, 1'b0, 1'b0, 1'b1);
    issue(3'd1, 16'h0, 8'hFF, 16'h0, 7'd0, 16'h0, 16'h0304, 1'b1);
    expect_all("R4 no loop", 16'h0302, 8'h00, 1'b0, 1'b0, 1'b0);
    issue(3'd1, 16'h0, 8'hFE, 16'h0, 7'd0, 16'h0, 16'h0002, 1'b0);
    expect_all("R4 wrap no loop", 16'hFFFE, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ind();
    issue(3'd2, 16'h0, 8'h00, 16'h0, 7'd0, 16'hC00A, 16'h2000, 1'b0);
    expect_all("R5", 16'hC00A, 8'h00, 1'b0, 1'b0, 1'b0);
    issue(3'd2, 16'h0, 8'h00, 16'h0, 7'd0, 16'h8001, 16'h2000, 1'b0);
    expect_all("R2 ind odd", 16'h2000, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_seg();
    issue(3'd3, 16'h0ABC, 8'h00, 16'h1234, 7'd0, 16'h0, 16'h2000, 1'b0);
    expect_all("R6", 16'h0ABC, 8'h34, 1'b1, 1'b0, 1'b0);
    issue(3'd3, 16'h0ABD, 8'h00, 16'h12FF, 7'd0, 16'h0, 16'h2000, 1'b0);
    expect_all("R2 seg odd", 16'h2000, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_trap();
    issue(3'd3, 16'h0100, 8'h00, 16'h00A5, 7'd0, 16'h0, 16'h2000, 1'b0);
    issue(3'd4, 16'h0001, 8'h00, 16'h0, 7'h7F, 16'h0, 16'h2000, 1'b0);
    expect_all("R7 max", 16'h01FC, 8'h00, 1'b1, 1'b0, 1'b0);
    issue(3'd4, 16'h0, 8'h00, 16'h0, 7'h00, 16'h0, 16'h2000, 1'b0);
    expect_all("R7 zero", 16'h0000, 8'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_resv();
    for (int m = 5; m < 8; m++) begin
      issue(3'(m), 16'h0003, 8'hFF, 16'h0077, 7'h11, 16'h0005, 16'h5552, 1'b0);
      expect_all("R10", 16'h5552, 8'h00, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_hold();
    issue(3'd4, 16'h0, 8'h00, 16'h0, 7'h05, 16'h0, 16'h0, 1'b0);
    mode_i = 3'd0; addr_i = 16'h7770; trap_no_i = 7'h3A;
    @(negedge clk);
    chk("R8 vld low", 32'(vld_o), 0);
    chk("R8 ip held", 32'(nxt_ip_o), 32'h14);
    chk("R8 seg_we held", 32'(seg_we_o), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_abs(); t_rel(); t_loop(); t_ind(); t_seg(); t_trap(); t_resv(); t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule